// File: doc/BRIEF.md
# Instruction Word Decoder with Length and Next-PC Selection

This block takes the leading 16-bit word of an instruction and splits it into its four four-bit fields: group, opcode, source operand and destination operand. Each operand field carries an addressing mode and a register number. From the two operand modes it works out how many extension words follow the leading word, and so the total instruction length of one to three words. It also raises a flag when the encoding cannot be legal.

The same block picks the program counter of the next instruction. For the jump group it chooses between the resolved jump target and the sequential address. A conditional jump tests a five-bit mask against the five condition flags. The caller supplies the current PC, the already-resolved target word, the mask and the flags. All results are registered once and presented together with a valid strobe one cycle after the request.

Top module: `instr_decode_unit`

## Requirements
- R1: The decoded fields are word bits [15:12] group, [11:8] opcode, [7:6] source mode, [5:4] source register, [3:2] destination mode and [1:0] destination register. Mode codes: 00 register, 01 memory, 10 literal, 11 register-indirect with offset.
- R2: The length is 1, plus 1 if the source mode is not 00, plus 1 if the destination mode is 01 or 11. It always lies between 1 and 3.
- R3: The illegal flag is set exactly when the destination mode is 10 (literal) or the group is greater than 4.
- R4: The condition is true when the OR over i = 0..4 of mask[i] AND flag[i] is 1. Flag bit order is 0 negative, 1 zero, 2 positive, 3 carry, 4 overflow. A mask of 3 therefore fires on zero or negative, and a mask of 16 fires on overflow only.
- R5: Group 3 opcode 0 always takes the target: next PC equals the target and the taken flag is 1.
- R6: Group 3 opcode 1 takes the target when the condition is true. Otherwise the next PC is PC plus length.
- R7: Group 3 opcode 2 takes the target when the condition is false. Otherwise the next PC is PC plus length.
- R8: Every other instruction, including group 3 opcodes 3 to 15, gives a next PC of PC plus length modulo 2^16, with the taken flag 0.
- R9: Results appear one clock after a request with the valid input high. When the valid input is low, the valid output drops on the next clock and all other outputs keep their values.
- R10: While reset is high, every output is cleared to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Request strobe |
| instr_i | input | 16 | Leading instruction word |
| pc_i | input | 16 | Address of this instruction |
| tgt_i | input | 16 | Resolved jump target |
| cc_mask_i | input | 5 | Condition mask |
| flags_i | input | 5 | Current condition flags (N,Z,P,C,O from bit 0) |
| vld_o | output | 1 | Result valid |
| grp_o | output | 4 | Group field |
| opc_o | output | 4 | Opcode field |
| src_mode_o | output | 2 | Source addressing mode |
| src_reg_o | output | 2 | Source register number |
| dst_mode_o | output | 2 | Destination addressing mode |
| dst_reg_o | output | 2 | Destination register number |
| len_o | output | 2 | Instruction length in words |
| illegal_o | output | 1 | Illegal encoding |
| taken_o | output | 1 | Jump target selected |
| next_pc_o | output | 16 | Next program counter |

## Verification
On every valid cycle, the assertions check the following:
- the length range;
- the two illegal cases;
- the relation of the registered next PC to the PC and target sampled one cycle earlier, for the always-jump, the two condition senses and the sequential path;
- the hold behaviour when idle;
- the reset state.

Field placement cannot be shown from the outputs alone, nor can the exact length for each mode pair. The bench's exhaustive sweep of all 65536 instruction words covers both. The full 32-by-32 sweep of mask against flags, the named mask examples and the wrap of the PC past 0xFFFF are also shown only by the bench's scenarios.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int NIB_W  = 4;
    localparam int MODE_W = 2;
    localparam int REGN_W = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_REG = 2'b00,
        AM_MEM = 2'b01,
        AM_LIT = 2'b10,
        AM_IDX = 2'b11
    } amode_e;

    typedef enum logic [NIB_W-1:0] {
        JOP_ALWAYS  = 4'd0,
        JOP_IFTRUE  = 4'd1,
        JOP_IFFALSE = 4'd2
    } jop_e;

    typedef struct packed {
        amode_e              mode;
        logic [REGN_W-1:0]   regn;
    } opfield_t;

    typedef struct packed {
        logic [NIB_W-1:0] grp;
        logic [NIB_W-1:0] opc;
        opfield_t         src;
        opfield_t         dst;
    } dec_t;

    // one extension word for any non-register source
    function automatic logic src_needs_ext(amode_e m);
        return m != AM_REG;
    endfunction

    // memory address or offset word after the destination
    function automatic logic dst_needs_ext(amode_e m);
        return (m == AM_MEM) || (m == AM_IDX);
    endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    localparam int FLD_W = 2 * NIB_W;

    logic [NIB_W-1:0] src_nib;
    logic [NIB_W-1:0] dst_nib;

    assign src_nib = word_i[FLD_W-1 -: NIB_W];
    assign dst_nib = word_i[NIB_W-1:0];

    always_comb begin
        dec_o.grp      = word_i[WORD_W-1 -: NIB_W];
        dec_o.opc      = word_i[WORD_W-NIB_W-1 -: NIB_W];
        dec_o.src.mode = amode_e'(src_nib[NIB_W-1 -: MODE_W]);
        dec_o.src.regn = src_nib[REGN_W-1:0];
        dec_o.dst.mode = amode_e'(dst_nib[NIB_W-1 -: MODE_W]);
        dec_o.dst.regn = dst_nib[REGN_W-1:0];
    end
endmodule

// File: rtl/idec_length.sv
module idec_length
    import idec_pkg::*;
#(
    parameter int MAX_GROUP = 4,
    parameter int LEN_W     = 2
) (
    input  logic [NIB_W-1:0] grp_i,
    input  amode_e           src_mode_i,
    input  amode_e           dst_mode_i,
    output logic [LEN_W-1:0] len_o,
    output logic             illegal_o
);
    logic s_ext;
    logic d_ext;

    assign s_ext = src_needs_ext(src_mode_i);
    assign d_ext = dst_needs_ext(dst_mode_i);

    always_comb begin
        len_o     = LEN_W'(1) + LEN_W'(s_ext) + LEN_W'(d_ext);
        illegal_o = (dst_mode_i == AM_LIT) ||
                    (grp_i > NIB_W'(MAX_GROUP));
    end
endmodule

// File: rtl/idec_branch.sv
module idec_branch
    import idec_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int FLAG_W     = 5,
    parameter int JUMP_GROUP = 3,
    parameter int LEN_W      = 2
) (
    input  logic [NIB_W-1:0]  grp_i,
    input  logic [NIB_W-1:0]  opc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] tgt_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              taken_o,
    output logic [WORD_W-1:0] next_pc_o
);
    logic [FLAG_W-1:0] hit;
    logic              cond;
    logic              is_jump;
    logic [WORD_W-1:0] seq_pc;

    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_hit
        assign hit[gi] = mask_i[gi] & flags_i[gi];
    end

    assign cond    = |hit;
    assign is_jump = (grp_i == NIB_W'(JUMP_GROUP));
    assign seq_pc  = pc_i + {{(WORD_W-LEN_W){1'b0}}, len_i};

    always_comb begin
        taken_o = 1'b0;
        if (is_jump) begin
            case (opc_i)
                JOP_ALWAYS:  taken_o = 1'b1;
                JOP_IFTRUE:  taken_o = cond;
                JOP_IFFALSE: taken_o = ~cond;
                default:     taken_o = 1'b0;
            endcase
        end
        next_pc_o = taken_o ? tgt_i : seq_pc;
    end
endmodule

// File: rtl/instr_decode_unit.sv
module instr_decode_unit
    import idec_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int FLAG_W     = 5,
    parameter int MAX_GROUP  = 4,
    parameter int JUMP_GROUP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] tgt_i,
    input  logic [FLAG_W-1:0] cc_mask_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              vld_o,
    output logic [3:0]        grp_o,
    output logic [3:0]        opc_o,
    output logic [1:0]        src_mode_o,
    output logic [1:0]        src_reg_o,
    output logic [1:0]        dst_mode_o,
    output logic [1:0]        dst_reg_o,
    output logic [1:0]        len_o,
    output logic              illegal_o,
    output logic              taken_o,
    output logic [WORD_W-1:0] next_pc_o
);
    localparam int LEN_W = 2;

    dec_t              dec;
    logic [LEN_W-1:0]  len_c;
    logic              illegal_c;
    logic              taken_c;
    logic [WORD_W-1:0] npc_c;

    idec_fields #(.WORD_W(WORD_W)) u_fields (
        .word_i (instr_i),
        .dec_o  (dec)
    );

    idec_length #(.MAX_GROUP(MAX_GROUP), .LEN_W(LEN_W)) u_length (
        .grp_i      (dec.grp),
        .src_mode_i (dec.src.mode),
        .dst_mode_i (dec.dst.mode),
        .len_o      (len_c),
        .illegal_o  (illegal_c)
    );

    idec_branch #(
        .WORD_W(WORD_W), .FLAG_W(FLAG_W),
        .JUMP_GROUP(JUMP_GROUP), .LEN_W(LEN_W)
    ) u_branch (
        .grp_i     (dec.grp),
        .opc_i     (dec.opc),
        .len_i     (len_c),
        .pc_i      (pc_i),
        .tgt_i     (tgt_i),
        .mask_i    (cc_mask_i),
        .flags_i   (flags_i),
        .taken_o   (taken_c),
        .next_pc_o (npc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o      <= 1'b0;
            grp_o      <= '0;
            opc_o      <= '0;
            src_mode_o <= '0;
            src_reg_o  <= '0;
            dst_mode_o <= '0;
            dst_reg_o  <= '0;
            len_o      <= '0;
            illegal_o  <= 1'b0;
            taken_o    <= 1'b0;
            next_pc_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                grp_o      <= dec.grp;
                opc_o      <= dec.opc;
                src_mode_o <= dec.src.mode;
                src_reg_o  <= dec.src.regn;
                dst_mode_o <= dec.dst.mode;
                dst_reg_o  <= dec.dst.regn;
                len_o      <= len_c;
                illegal_o  <= illegal_c;
                taken_o    <= taken_c;
                next_pc_o  <= npc_c;
            end
        end
    end
endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
    parameter int WORD_W     = 16,
    parameter int FLAG_W     = 5,
    parameter int MAX_GROUP  = 4,
    parameter int JUMP_GROUP = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              vld_i,
    input logic [WORD_W-1:0] pc_i,
    input logic [WORD_W-1:0] tgt_i,
    input logic [FLAG_W-1:0] cc_mask_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic              vld_o,
    input logic [3:0]        grp_o,
    input logic [3:0]        opc_o,
    input logic [1:0]        dst_mode_o,
    input logic [1:0]        len_o,
    input logic              illegal_o,
    input logic              taken_o,
    input logic [WORD_W-1:0] next_pc_o
);
    logic jg;
    assign jg = vld_o && (grp_o == 4'(JUMP_GROUP));

    assert_len_range_R2: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (len_o != 2'd0));

    assert_lit_dst_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_o && dst_mode_o == 2'b10) |-> illegal_o);

    assert_high_group_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_o && grp_o > 4'(MAX_GROUP)) |-> illegal_o);

    assert_cond_true_R4: assert property (@(posedge clk) disable iff (rst)
        (jg && opc_o == 4'd1) |->
            (taken_o == (($past(cc_mask_i) & $past(flags_i)) != '0)));

    assert_always_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (jg && opc_o == 4'd0) |-> (taken_o && next_pc_o == $past(tgt_i)));

    assert_take_target_R6: assert property (@(posedge clk) disable iff (rst)
        (vld_o && taken_o) |-> (next_pc_o == $past(tgt_i)));

    assert_cond_false_R7: assert property (@(posedge clk) disable iff (rst)
        (jg && opc_o == 4'd2) |->
            (taken_o == (($past(cc_mask_i) & $past(flags_i)) == '0)));

    assert_seq_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !taken_o) |->
            (next_pc_o == WORD_W'($past(pc_i) + {{(WORD_W-2){1'b0}}, len_o})));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!vld_o && $stable(next_pc_o) && $stable(len_o)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!vld_o && next_pc_o == '0 && len_o == 2'd0 && !taken_o));
endmodule

bind instr_decode_unit idec_checker #(
    .WORD_W(WORD_W), .FLAG_W(FLAG_W),
    .MAX_GROUP(MAX_GROUP), .JUMP_GROUP(JUMP_GROUP)
) u_chk (
    .clk(clk), .rst(rst), .vld_i(vld_i), .pc_i(pc_i), .tgt_i(tgt_i),
    .cc_mask_i(cc_mask_i), .flags_i(flags_i), .vld_o(vld_o),
    .grp_o(grp_o), .opc_o(opc_o), .dst_mode_o(dst_mode_o), .len_o(len_o),
    .illegal_o(illegal_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
);

// File: tb/instr_decode_unit_test.sv
`timescale 1ns/1ps
module instr_decode_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] tgt_i = '0;
    logic [4:0]  cc_mask_i = '0;
    logic [4:0]  flags_i = '0;
    logic        vld_o;
    logic [3:0]  grp_o, opc_o;
    logic [1:0]  src_mode_o, src_reg_o, dst_mode_o, dst_reg_o, len_o;
    logic        illegal_o, taken_o;
    logic [15:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // pending expectation for the request driven one cycle earlier
    bit          pend = 0;
    logic [15:0] e_word, e_npc;
    logic [1:0]  e_len;
    logic        e_ill, e_tk;
    string       e_tag;

    always #4 clk = ~clk;

    instr_decode_unit uut (
        .clk(clk), .rst(rst), .vld_i(vld_i), .instr_i(instr_i),
        .pc_i(pc_i), .tgt_i(tgt_i), .cc_mask_i(cc_mask_i), .flags_i(flags_i),
        .vld_o(vld_o), .grp_o(grp_o), .opc_o(opc_o),
        .src_mode_o(src_mode_o), .src_reg_o(src_reg_o),
        .dst_mode_o(dst_mode_o), .dst_reg_o(dst_reg_o),
        .len_o(len_o), .illegal_o(illegal_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk("R9 valid", {31'd0, vld_o}, 32'd1);
            chk("R1 fields", {16'd0, grp_o, opc_o, src_mode_o, src_reg_o, dst_mode_o, dst_reg_o},
                {16'd0, e_word});
            chk("R2 length", {30'd0, len_o}, {30'd0, e_len});
            chk("R3 illegal", {31'd0, illegal_o}, {31'd0, e_ill});
            chk({e_tag, " taken R4"}, {31'd0, taken_o}, {31'd0, e_tk});
            chk({e_tag, " next pc"}, {16'd0, next_pc_o}, {16'd0, e_npc});
        end
    endtask

    task automatic step(input int w, input int pc, input int tgt, input int m, input int f);
        int g, o, sm, dm, ln;
        bit cnd;
        @(negedge clk);
        check_pending();
        g  = (w >> 12) & 15;
        o  = (w >> 8) & 15;
        sm = (w >> 6) & 3;
        dm = (w >> 2) & 3;
        ln = 1 + ((sm != 0) ? 1 : 0) + ((dm == 1 || dm == 3) ? 1 : 0);
        cnd = (m & f & 31) != 0;
        e_word = w[15:0];
        e_len  = ln[1:0];
        e_ill  = (dm == 2) || (g > 4);
        e_tk   = (g == 3) && ((o == 0) || (o == 1 && cnd) || (o == 2 && !cnd));
        e_npc  = e_tk ? tgt[15:0] : 16'((pc + ln) % 65536);
        if (g == 3 && o == 0)      e_tag = "R5";
        else if (g == 3 && o == 1) e_tag = "R6";
        else if (g == 3 && o == 2) e_tag = "R7";
        else                       e_tag = "R8";
        pend = 1;
        vld_i = 1'b1; instr_i = w[15:0]; pc_i = pc[15:0]; tgt_i = tgt[15:0];
        cc_mask_i = m[4:0]; flags_i = f[4:0];
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
        pend = 0;
        vld_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {31'd0, vld_o}, 32'd0);
        chk("R10 reset pc", {16'd0, next_pc_o}, 32'd0);
        chk("R10 reset len", {30'd0, len_o}, 32'd0);
        rst = 1'b0;

        // exhaustive sweep over every leading word (R1, R2, R3, R5..R8)
        for (int w = 0; w < 65536; w++)
            step(w, (w * 37 + 11) & 16'hFFFF, w ^ 16'h5AA5, (w * 5) & 31, ((w * 3) >> 2) & 31);

        // full mask x flags sweep for both condition senses (R4, R6, R7), PC wraps (R8)
        for (int m = 0; m < 32; m++)
            for (int f = 0; f < 32; f++) begin
                step(16'h3105, 16'hFFFF, 16'h1234, m, f);
                step(16'h3205, 16'hFFFF, 16'h4321, m, f);
            end

        // R4 named cases: mask 3 -> zero or negative, mask 16 -> overflow only
        step(16'h3105, 16'h0100, 16'h0800, 3, 5'b00010);
        step(16'h3105, 16'h0100, 16'h0800, 3, 5'b00001);
        step(16'h3105, 16'h0100, 16'h0800, 3, 5'b11100);
        step(16'h3105, 16'h0100, 16'h0800, 16, 5'b10000);
        step(16'h3105, 16'h0100, 16'h0800, 16, 5'b01111);
        // R8 wrap with three-word length: FFFE + 3 = 0001
        step(16'h05D4, 16'hFFFE, 16'h7777, 0, 0);
        held = e_npc;
        flush();

        // R9: idle cycles with changing inputs leave results in place
        instr_i = 16'h3000; tgt_i = 16'hBEEF; pc_i = 16'h0042;
        @(negedge clk);
        chk("R9 idle valid", {31'd0, vld_o}, 32'd0);
        chk("R9 idle hold pc", {16'd0, next_pc_o}, {16'd0, held});
        chk("R9 idle hold len", {30'd0, len_o}, 32'd3);

        // R10: reset in mid-run clears even with a request present
        step(16'h3005, 16'h0010, 16'hAAAA, 0, 0);
        flush();
        rst = 1'b1; vld_i = 1'b1;
        @(negedge clk);
        chk("R10 mid reset valid", {31'd0, vld_o}, 32'd0);
        chk("R10 mid reset pc", {16'd0, next_pc_o}, 32'd0);
        chk("R10 mid reset taken", {31'd0, taken_o}, 32'd0);
        rst = 1'b0; vld_i = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule